// File: doc/BRIEF.md
# Two-Stage Local Tick Timer

This block is a per-core event timer driven from a small register window. A prescaler divides the input clock into ticks. Each tick decrements an interrupt counter. When that counter expires, a sticky interrupt flag is raised. If interval mode is selected, the counter reloads from its buffer and runs again. Otherwise it stops and drops its own run bit. The prescaler and the interrupt counter each have their own run bit in the control register, so software can halt or resume them separately.

Writes to the two buffer registers and to the control register do not take effect at once. Each one passes through a fixed three-cycle commit pipe. On the edge where it commits, the matching flag in the write-status register is set, so software can poll for completion. The interrupt output is the sticky flag gated by an enable bit. Reads are combinational from the addressed register.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register (offsets 0x00, 0x08, 0x20, 0x30, 0x34, 0x40) reads zero and `irq_o` is low.
- R2: With control bit 0 set, a tick-buffer value N at offset 0x00 gives one tick every N+1 clocks. A committed tick-buffer write reloads the prescaler with the new value.
- R3: With control bit 1 set, each tick decrements the interrupt counter. A tick that arrives while the counter is zero is an expiry, so a count of C expires on the (C+1)th tick.
- R4: A write to offset 0x08 stores bits 30:0 in the count buffer. If bit 31 of the write is 1, the counter is also loaded with bits 30:0 at commit. Bit 31 always reads back as 0.
- R5: With control bit 2 clear (one-shot), an expiry leaves the counter at zero and clears control bit 1.
- R6: With control bit 2 set (interval), an expiry reloads the counter from the count buffer, and counting continues.
- R7: Bit 0 at offset 0x30 is set by an expiry and stays set until it is cleared by writing 1. If an expiry falls on the same edge as the clear, the bit stays set.
- R8: `irq_o` equals status bit 0 ANDed with enable bit 0 at offset 0x34. A write to the enable register takes effect on the next edge.
- R9: Writes to offsets 0x00, 0x08 and 0x20 take effect on the third clock edge after the write edge. On that same commit edge they set bit 0, bit 1 and bit 3 at offset 0x40, respectively. Those bits are cleared by writing 1, and a commit on the same edge wins over the clear.
- R10: With control bits 0 and 1 both clear, the prescaler and the counter hold their values and the buffers are unchanged. Setting the run bits again resumes from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a counter expiry and a software clear of the sticky status bit. The second is a delayed commit and a software clear of the matching write-status bit. The bench provokes the first by watching its reference model at each falling edge and issuing the status clear exactly when the model predicts an expiry on the next edge. It provokes the second by timing a write-status clear to the third edge after a control write. In both cases the bit must read 1 afterwards, and the per-cycle model comparison confirms that nothing else moved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_TICKBUF = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNTBUF  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ENB     = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_WSTAT   = 8'h40;

  localparam int CTL_TICK_RUN = 0;
  localparam int CTL_CNT_RUN  = 1;
  localparam int CTL_INTERVAL = 2;
  localparam int CTRL_W       = 3;
  localparam int LOAD_BIT     = 31;

  // commit lanes, indexed in this order
  localparam int LANE_TICK = 0;
  localparam int LANE_CNT  = 1;
  localparam int LANE_CTRL = 2;
  localparam int NUM_LANES = 3;

  // bit of the write-status register owned by each lane
  function automatic int wstat_pos(input int lane);
    case (lane)
      LANE_TICK: return 0;
      LANE_CNT:  return 1;
      default:   return 3;
    endcase
  endfunction

  // a tick arrives when the prescaler is running and has reached zero
  function automatic logic tick_due(input logic run, input logic at_zero);
    return run && at_zero;
  endfunction

  // an expiry is a tick seen while the counter is running at zero
  function automatic logic expiry_due(input logic tick, input logic run, input logic at_zero);
    return tick && run && at_zero;
  endfunction
endpackage

// File: rtl/tmr_commit_lane.sv
module tmr_commit_lane #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_data_i,
  output logic          commit_o,
  output logic [DW-1:0] commit_data_o
);
  logic [LAT-1:0] vld_q;
  logic [DW-1:0]  dat_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) dat_q[i] <= '0;
    end else begin
      vld_q[0] <= cap_i;
      dat_q[0] <= cap_data_i;
      for (int i = 1; i < LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign commit_o      = vld_q[LAT-1];
  assign commit_data_o = dat_q[LAT-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic [PW-1:0] reload_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = tick_due(run_i, cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= tick_o ? reload_i : cnt_q - PW'(1);
  end
endmodule

// File: rtl/tmr_intcnt.sv
module tmr_intcnt
  import tmr_pkg::*;
#(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          interval_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] reload_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step     = tick_i && run_i;
  assign expire_o = expiry_due(tick_i, run_i, cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= interval_i ? reload_i : '0;
    else if (step)     cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W      = 32,
  parameter int CNT_W      = 31,
  parameter int COMMIT_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_LANE_W = CNT_W + 1;

  // write decode
  logic tb_cap, cnt_cap, ctrl_cap, stat_clr_wr, enb_wr, wstat_clr_wr;
  assign tb_cap       = bus_wr && (bus_addr == OFS_TICKBUF);
  assign cnt_cap      = bus_wr && (bus_addr == OFS_CNTBUF);
  assign ctrl_cap     = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_clr_wr  = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[0];
  assign enb_wr       = bus_wr && (bus_addr == OFS_ENB);
  assign wstat_clr_wr = bus_wr && (bus_addr == OFS_WSTAT);

  // delayed commit lanes
  logic                  tb_commit, cnt_commit, ctrl_commit;
  logic [PRE_W-1:0]      tb_data;
  logic [CNT_LANE_W-1:0] cnt_data;
  logic [CTRL_W-1:0]     ctrl_data;

  tmr_commit_lane #(.DW(PRE_W), .LAT(COMMIT_LAT)) u_lane_tick (
    .clk(clk), .rst_n(rst_n), .cap_i(tb_cap), .cap_data_i(bus_wdata[PRE_W-1:0]),
    .commit_o(tb_commit), .commit_data_o(tb_data));

  tmr_commit_lane #(.DW(CNT_LANE_W), .LAT(COMMIT_LAT)) u_lane_cnt (
    .clk(clk), .rst_n(rst_n), .cap_i(cnt_cap),
    .cap_data_i({bus_wdata[LOAD_BIT], bus_wdata[CNT_W-1:0]}),
    .commit_o(cnt_commit), .commit_data_o(cnt_data));

  tmr_commit_lane #(.DW(CTRL_W), .LAT(COMMIT_LAT)) u_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_i(ctrl_cap), .cap_data_i(bus_wdata[CTRL_W-1:0]),
    .commit_o(ctrl_commit), .commit_data_o(ctrl_data));

  logic [NUM_LANES-1:0] lane_commit;
  assign lane_commit[LANE_TICK] = tb_commit;
  assign lane_commit[LANE_CNT]  = cnt_commit;
  assign lane_commit[LANE_CTRL] = ctrl_commit;

  // architectural registers
  logic [PRE_W-1:0]     tb_q;
  logic [CNT_W-1:0]     icb_q;
  logic [CTRL_W-1:0]    ctrl_q;
  logic                 st_q, en_q;
  logic [NUM_LANES-1:0] ws_q;

  // named events between the stages
  logic tick_ev, expire_ev, cnt_load;
  assign cnt_load = cnt_commit && cnt_data[CNT_W];

  tmr_prescaler #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q[CTL_TICK_RUN]),
    .load_i(tb_commit), .load_val_i(tb_data), .reload_i(tb_q), .tick_o(tick_ev));

  tmr_intcnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_ev), .run_i(ctrl_q[CTL_CNT_RUN]),
    .interval_i(ctrl_q[CTL_INTERVAL]), .load_i(cnt_load),
    .load_val_i(cnt_data[CNT_W-1:0]), .reload_i(icb_q), .expire_o(expire_ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q   <= '0;
      icb_q  <= '0;
      ctrl_q <= '0;
      st_q   <= 1'b0;
      en_q   <= 1'b0;
      ws_q   <= '0;
    end else begin
      if (tb_commit)  tb_q  <= tb_data;
      if (cnt_commit) icb_q <= cnt_data[CNT_W-1:0];
      if (ctrl_commit)
        ctrl_q <= ctrl_data;
      else if (expire_ev && !ctrl_q[CTL_INTERVAL])
        ctrl_q[CTL_CNT_RUN] <= 1'b0;
      if (expire_ev)        st_q <= 1'b1;
      else if (stat_clr_wr) st_q <= 1'b0;
      if (enb_wr) en_q <= bus_wdata[0];
      for (int i = 0; i < NUM_LANES; i++) begin
        if (lane_commit[i])
          ws_q[i] <= 1'b1;
        else if (wstat_clr_wr && bus_wdata[wstat_pos(i)])
          ws_q[i] <= 1'b0;
      end
    end
  end

  assign irq_o = st_q && en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_TICKBUF: bus_rdata[PRE_W-1:0]  = tb_q;
      OFS_CNTBUF:  bus_rdata[CNT_W-1:0]  = icb_q;
      OFS_CTRL:    bus_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_STAT:    bus_rdata[0]          = st_q;
      OFS_ENB:     bus_rdata[0]          = en_q;
      OFS_WSTAT: begin
        for (int i = 0; i < NUM_LANES; i++) bus_rdata[wstat_pos(i)] = ws_q[i];
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int PRE_W  = 32,
  parameter int CNT_W  = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_ev,
  input logic             expire_ev,
  input logic             tb_commit,
  input logic             ctrl_commit,
  input logic             cnt_load,
  input logic [CNT_W:0]   cnt_data,
  input logic [PRE_W-1:0] tb_q,
  input logic [CNT_W-1:0] icb_q,
  input logic [2:0]       ctrl_q,
  input logic             st_q,
  input logic [2:0]       ws_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] int_cnt
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ev && tb_q != '0 && !tb_commit) |=> !tick_ev);

  // R4
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (int_cnt == $past(cnt_data[CNT_W-1:0])));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && !ctrl_q[2] && !ctrl_commit && !cnt_load) |=> (!ctrl_q[1] && int_cnt == '0));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && ctrl_q[2] && !cnt_load) |=> (int_cnt == $past(icb_q)));

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> st_q);

  // R9
  wstat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_commit |=> ws_q[2]);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !ctrl_q[1] && !tb_commit && !cnt_load) |=> ($stable(pre_cnt) && $stable(int_cnt)));
endmodule

bind tick_timer tick_timer_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ev(tick_ev), .expire_ev(expire_ev),
  .tb_commit(tb_commit), .ctrl_commit(ctrl_commit), .cnt_load(cnt_load),
  .cnt_data(cnt_data), .tb_q(tb_q), .icb_q(icb_q), .ctrl_q(ctrl_q),
  .st_q(st_q), .ws_q(ws_q), .pre_cnt(u_pre.cnt_q), .int_cnt(u_cnt.cnt_q));

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h40;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [7:0]  watch = 8'h40;

  always #2.5 clk = ~clk;

  tick_timer uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  int checks = 0;
  int fails = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_tb, m_pre;
  logic [30:0] m_icb, m_ic;
  logic [2:0]  m_ctl, m_ws;
  logic        m_st, m_en;
  int          cyc;
  int          q_due[$];
  int          q_lane[$];
  logic [31:0] q_dat[$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_tb;
      8'h08: return {1'b0, m_icb};
      8'h20: return {29'd0, m_ctl};
      8'h30: return {31'd0, m_st};
      8'h34: return {31'd0, m_en};
      8'h40: return {28'd0, m_ws[2], 1'b0, m_ws[1], m_ws[0]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08: return "R4";
      8'h20: return "R5";
      8'h30: return "R7";
      8'h34: return "R8";
      8'h40: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic bit will_expire();
    return m_ctl[0] && m_pre == 0 && m_ctl[1] && m_ic == 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tb = 0; m_pre = 0; m_icb = 0; m_ic = 0; m_ctl = 0; m_ws = 0;
      m_st = 0; m_en = 0; cyc = 0;
      q_due.delete(); q_lane.delete(); q_dat.delete();
    end else begin
      bit tk, ex;
      bit c_tb, c_ic, c_ct;
      logic [31:0] d_tb, d_ic, d_ct;
      logic [31:0] n_pre;
      logic [30:0] n_ic;
      c_tb = 0; c_ic = 0; c_ct = 0; d_tb = 0; d_ic = 0; d_ct = 0;
      tk = m_ctl[0] && (m_pre == 0);
      ex = tk && m_ctl[1] && (m_ic == 0);
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        case (q_lane[0])
          0: begin c_tb = 1; d_tb = q_dat[0]; end
          1: begin c_ic = 1; d_ic = q_dat[0]; end
          default: begin c_ct = 1; d_ct = q_dat[0]; end
        endcase
        void'(q_due.pop_front()); void'(q_lane.pop_front()); void'(q_dat.pop_front());
      end
      if (c_tb) n_pre = d_tb;
      else if (m_ctl[0]) n_pre = (m_pre == 0) ? m_tb : m_pre - 1;
      else n_pre = m_pre;
      if (c_ic && d_ic[31]) n_ic = d_ic[30:0];
      else if (ex) n_ic = m_ctl[2] ? m_icb : 31'd0;
      else if (tk && m_ctl[1]) n_ic = m_ic - 1;
      else n_ic = m_ic;
      if (ex) m_st = 1;
      else if (bus_wr && bus_addr == 8'h30 && bus_wdata[0]) m_st = 0;
      for (int i = 0; i < 3; i++) begin
        int pos;
        bit cm;
        pos = (i == 2) ? 3 : i;
        cm = (i == 0) ? c_tb : (i == 1) ? c_ic : c_ct;
        if (cm) m_ws[i] = 1;
        else if (bus_wr && bus_addr == 8'h40 && bus_wdata[pos]) m_ws[i] = 0;
      end
      if (c_ct) m_ctl = d_ct[2:0];
      else if (ex && !m_ctl[2]) m_ctl[1] = 0;
      if (bus_wr && bus_addr == 8'h34) m_en = bus_wdata[0];
      if (c_tb) m_tb = d_tb;
      if (c_ic) m_icb = d_ic[30:0];
      m_pre = n_pre;
      m_ic = n_ic;
      if (bus_wr && (bus_addr == 8'h00 || bus_addr == 8'h08 || bus_addr == 8'h20)) begin
        q_due.push_back(cyc + 3);
        q_lane.push_back(bus_addr == 8'h00 ? 0 : (bus_addr == 8'h08 ? 1 : 2));
        q_dat.push_back(bus_wdata);
      end
      cyc++;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (cmp_en && !done) begin
      check("R8 irq", {31'd0, irq_o}, {31'd0, m_st && m_en});
      check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = watch; bus_wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_addr = watch;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1;
    cmp_en = 1;
    // R1 reset state
    peek("R1", 8'h00, 0); peek("R1", 8'h08, 0); peek("R1", 8'h20, 0);
    peek("R1", 8'h30, 0); peek("R1", 8'h34, 0); peek("R1", 8'h40, 0);
    check("R1 irq", {31'd0, irq_o}, 0);

    // R9 commit delay of the tick buffer
    wr(8'h00, 32'd4);
    @(posedge clk); #1; check("R9 edge1", bus_rdata, 0);
    @(posedge clk); #1; check("R9 edge2", bus_rdata, 0);
    @(posedge clk); #1; check("R9 edge3", bus_rdata, 32'h1);
    wr(8'h40, 32'h1);
    check("R9 clear", bus_rdata, 0);

    // R4 load strobe, R3/R5 one-shot expiry
    wr(8'h08, 32'h8000_0003);
    wr(8'h08, 32'h0000_0005);
    wr(8'h34, 32'h1);
    wr(8'h20, 32'h3);
    idle(6);
    peek("R4", 8'h08, 32'd5);
    idle(40);
    peek("R7", 8'h30, 1);
    peek("R5", 8'h20, 1);
    check("R8 irq", {31'd0, irq_o}, 1);
    idle(10);
    peek("R7 sticky", 8'h30, 1);
    watch = 8'h30;
    wr(8'h30, 32'h1);
    check("R7 clear", {31'd0, irq_o}, 0);

    // R6 interval mode
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'h7);
    idle(60);
    peek("R6", 8'h30, 1);
    peek("R6", 8'h20, 7);

    // R7 clear colliding with an expiry
    begin
      bit hit;
      hit = 0;
      for (int k = 0; k < 200 && !hit; k++) begin
        @(negedge clk);
        if (will_expire()) hit = 1;
      end
      check("R7 collide found", {31'd0, hit}, 1);
      bus_wr = 1; bus_addr = 8'h30; bus_wdata = 1;
      @(negedge clk);
      bus_wr = 0; bus_wdata = 0;
      check("R7 collide", bus_rdata, 1);
    end

    // R2 prescaler reload while running
    wr(8'h00, 32'd0);
    idle(5);
    wr(8'h30, 32'h1);
    idle(5);
    peek("R2", 8'h30, 1);

    // R9 write-status clear colliding with a commit
    watch = 8'h40;
    wr(8'h40, 32'hB);
    wr(8'h20, 32'h7);
    idle(2);
    bus_wr = 1; bus_addr = 8'h40; bus_wdata = 32'h8;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
    peek("R9 collide", 8'h40, 32'h8);

    // R10 halt keeps buffers, no expiry
    watch = 8'h30;
    wr(8'h20, 32'h0);
    idle(5);
    wr(8'h30, 32'h1);
    idle(80);
    peek("R10", 8'h30, 0);
    peek("R10", 8'h00, 0);
    peek("R10", 8'h08, 2);
    wr(8'h20, 32'h3);
    idle(20);
    peek("R10", 8'h20, 1);
    peek("R10", 8'h30, 1);

    // R8 enable gating
    wr(8'h34, 32'h0);
    check("R8 gated", {31'd0, irq_o}, 0);
    peek("R8", 8'h30, 1);
    wr(8'h34, 32'h1);
    check("R8 open", {31'd0, irq_o}, 1);

    // R3 count timing: 11 ticks of 2 clocks
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8000_000A);
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h3);
    idle(8);
    peek("R3 early", 8'h30, 0);
    idle(40);
    peek("R3 late", 8'h30, 1);
    peek("R5", 8'h20, 1);

    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule